// File: doc/BRIEF.md
# Single-Cycle RISC Subset Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. In each cycle it fetches a word from an instruction memory, decodes it, and reads two registers from a 32-entry register file. The ALU then computes a result. A load or store is given to a byte-addressed data memory, and the result or the loaded word is written back at the clock edge. In the same cycle the core picks the next program counter. That value is the following word, a taken conditional branch target, or an absolute jump target.

It executes a small fixed-format subset: register-register add, subtract, AND, OR, NOR and logical shifts; add-immediate; word load and store; branch-if-not-equal; and an unconditional jump. Both memories sit outside the core and are read combinationally. The instruction port carries a word index. The data port carries an aligned byte address and four byte lanes, so the memory can be a plain byte array.

Top module: `rc_core`

## Requirements
- R1: While rst_ni is low, the PC is 0, imem_addr_o is 0 and dmem_we_o is low. After reset every register reads 0 until it is written.
- R2: Register 0 always reads 0. Any write aimed at register 0, from arithmetic or from a load, leaves it 0.
- R3: Opcode 0 (bits 31:26) is the register format: sources rs in bits 25:21 and rt in bits 20:16, destination rd in bits 15:11. The function code in bits 5:0 selects add = 32, sub = 34 (rs minus rt), and = 36, or = 37, nor = 39 (NOT of rs OR rt).
- R4: Function codes 0 and 2 shift rt left or right (logical) by the amount in bits 10:6. The rs field has no effect on the result.
- R5: Opcode 8 adds rs to the sign-extended 16-bit immediate in bits 15:0 and writes the sum to rt.
- R6: Opcode 35 loads a word into rt and opcode 43 stores rt. The address is rs plus the sign-extended immediate, with its two low bits forced to 0. dmem_we_o is high only in a store's cycle.
- R7: Memory is big-endian. Lane k (bits 8k+7:8k of the lane ports) is the byte at address+k, and the byte at the lowest address is the most significant byte of the register word.
- R8: Any instruction other than a taken branch or a jump advances imem_addr_o by exactly one word in the next cycle.
- R9: Opcode 5 compares rs and rt. If they differ, the next PC is PC+4 plus the sign-extended immediate times 4. If they are equal, the next PC is PC+4.
- R10: Opcode 2 jumps to the upper 4 bits of PC+4 followed by bits 25:0 shifted left by 2.
- R11: An undefined opcode, or opcode 0 with an undefined function code, writes no register and no memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 30 | Instruction word index (PC divided by 4) |
| imem_rdata_i | input | 32 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 32 | Word-aligned data byte address |
| dmem_we_o | output | 1 | Store strobe, written at the clock edge |
| dmem_wlanes_o | output | 32 | Store data, lane k is byte at address+k |
| dmem_rlanes_i | input | 32 | Load data, lane k is byte at address+k |

## Verification
In a single-cycle core, a register is read and written within the same cycle whenever an instruction names the same register as both a source and its destination. Examples are add $1,$1,$1 and the decrementing counter of a backward branch loop. The operands must come from the old value and the write must land at the edge. The bench triggers this case with a read-modify-write of the same register, a three-pass counting loop, and writes aimed at register 0 that are read back in the next instruction. Each case is judged by the word that a later store leaves in the byte array.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int XLEN  = 32;
  localparam int NREG  = 32;
  localparam int RAW   = $clog2(NREG);
  localparam int NLANE = XLEN / 8;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_SLL = 6'd0;
  localparam logic [5:0] FN_SRL = 6'd2;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLL, ALU_SRL
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    dst_rt;
    logic    b_imm;
    alu_op_e alu_op;
    logic    mem_we;
    logic    mem_rd;
    logic    br_ne;
    logic    jump;
  } ctrl_t;
endpackage

// File: rtl/rc_decode.sv
module rc_decode
  import rc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] fn_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_op = ALU_ADD;
    case (op_i)
      OP_RTYPE: begin
        ctrl_o.rf_we = 1'b1;
        case (fn_i)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_NOR:  ctrl_o.alu_op = ALU_NOR;
          FN_SLL:  ctrl_o.alu_op = ALU_SLL;
          FN_SRL:  ctrl_o.alu_op = ALU_SRL;
          default: ctrl_o.rf_we  = 1'b0;  // undefined funct: no-op
        endcase
      end
      OP_ADDI: begin
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.dst_rt = 1'b1;
        ctrl_o.b_imm  = 1'b1;
      end
      OP_LW: begin
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.dst_rt = 1'b1;
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.mem_rd = 1'b1;
      end
      OP_SW: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.mem_we = 1'b1;
      end
      OP_BNE:  ctrl_o.br_ne = 1'b1;
      OP_J:    ctrl_o.jump  = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/rc_regfile.sv
module rc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RAW-1:0]  ra_i,
  input  logic [RAW-1:0]  rb_i,
  output logic [XLEN-1:0] da_o,
  output logic [XLEN-1:0] db_o,
  input  logic            we_i,
  input  logic [RAW-1:0]  wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] rd_arr [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign rd_arr[i] = '0;
    end else begin : g_live
      logic [XLEN-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        q <= '0;
        else if (we_i && wa_i == RAW'(i))   q <= wd_i;
      end
      assign rd_arr[i] = q;
    end
  end

  assign da_o = rd_arr[ra_i];
  assign db_o = rd_arr[rb_i];
endmodule

// File: rtl/rc_alu.sv
module rc_alu
  import rc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [4:0]      shamt_i,
  output logic [XLEN-1:0] y_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_NOR: y_o = ~(a_i | b_i);
      ALU_SLL: y_o = b_i << shamt_i;
      ALU_SRL: y_o = b_i >> shamt_i;
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/rc_next_pc.sv
module rc_next_pc #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [15:0]     imm_i,
  input  logic [25:0]     jidx_i,
  input  logic            br_ne_i,
  input  logic            ne_i,
  input  logic            jump_i,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] pc_p4, br_tgt, j_tgt, br_off;

  assign pc_p4  = pc_i + XLEN'(4);
  assign br_off = {{(XLEN-18){imm_i[15]}}, imm_i, 2'b00};
  assign br_tgt = pc_p4 + br_off;
  assign j_tgt  = {pc_p4[XLEN-1:XLEN-4], jidx_i, 2'b00};

  always_comb begin
    if (jump_i)              pc_o = j_tgt;
    else if (br_ne_i && ne_i) pc_o = br_tgt;
    else                      pc_o = pc_p4;
  end
endmodule

// File: rtl/rc_core.sv
module rc_core
  import rc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-3:0] imem_addr_o,
  input  logic [XLEN-1:0] imem_rdata_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic            dmem_we_o,
  output logic [XLEN-1:0] dmem_wlanes_o,
  input  logic [XLEN-1:0] dmem_rlanes_i
);
  logic [XLEN-1:0] pc_q, pc_d;
  ctrl_t           ctrl;
  logic [RAW-1:0]  rs_a, rt_a, rd_a, wa;
  logic [XLEN-1:0] rs_data, rt_data, imm_sx, alu_b, alu_y, ld_word, wb_data;
  logic            rf_we;

  assign rs_a   = imem_rdata_i[25:21];
  assign rt_a   = imem_rdata_i[20:16];
  assign rd_a   = imem_rdata_i[15:11];
  assign imm_sx = {{(XLEN-16){imem_rdata_i[15]}}, imem_rdata_i[15:0]};

  rc_decode u_dec (
    .op_i   (imem_rdata_i[31:26]),
    .fn_i   (imem_rdata_i[5:0]),
    .ctrl_o (ctrl)
  );

  assign wa    = ctrl.dst_rt ? rt_a : rd_a;
  assign rf_we = ctrl.rf_we;

  rc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (rs_a),
    .rb_i   (rt_a),
    .da_o   (rs_data),
    .db_o   (rt_data),
    .we_i   (rf_we),
    .wa_i   (wa),
    .wd_i   (wb_data)
  );

  assign alu_b = ctrl.b_imm ? imm_sx : rt_data;

  rc_alu #(.XLEN(XLEN)) u_alu (
    .op_i    (ctrl.alu_op),
    .a_i     (rs_data),
    .b_i     (alu_b),
    .shamt_i (imem_rdata_i[10:6]),
    .y_o     (alu_y)
  );

  // big-endian: lane 0 (lowest address) carries the MSB
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    assign ld_word[XLEN-1-8*k -: 8] = dmem_rlanes_i[8*k +: 8];
    assign dmem_wlanes_o[8*k +: 8]  = rt_data[XLEN-1-8*k -: 8];
  end

  assign wb_data     = ctrl.mem_rd ? ld_word : alu_y;
  assign dmem_addr_o = {alu_y[XLEN-1:2], 2'b00};
  assign dmem_we_o   = ctrl.mem_we & rst_ni;

  rc_next_pc #(.XLEN(XLEN)) u_npc (
    .pc_i    (pc_q),
    .imm_i   (imem_rdata_i[15:0]),
    .jidx_i  (imem_rdata_i[25:0]),
    .br_ne_i (ctrl.br_ne),
    .ne_i    (rs_data != rt_data),
    .jump_i  (ctrl.jump),
    .pc_o    (pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign imem_addr_o = pc_q[XLEN-1:2];
endmodule

// File: rtl/rc_core_chk.sv
module rc_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [29:0] imem_addr_i,
  input logic [31:0] imem_rdata_i,
  input logic        dmem_we_i,
  input logic [31:0] rs_data_i,
  input logic [31:0] rt_data_i,
  input logic        rf_we_i
);
  logic [5:0]  op, fn;
  logic [29:0] off_w, nxt_w;
  logic        fn_ok, ins_ok;
  logic        unused_bits;

  assign op     = imem_rdata_i[31:26];
  assign fn     = imem_rdata_i[5:0];
  assign off_w  = {{14{imem_rdata_i[15]}}, imem_rdata_i[15:0]};
  assign nxt_w  = imem_addr_i + 30'd1;
  assign fn_ok  = fn == 6'd0 || fn == 6'd2 || fn == 6'd32 || fn == 6'd34 ||
                  fn == 6'd36 || fn == 6'd37 || fn == 6'd39;
  assign ins_ok = (op == 6'd0 && fn_ok) || op == 6'd2 || op == 6'd5 ||
                  op == 6'd8 || op == 6'd35 || op == 6'd43;
  assign unused_bits = ^{imem_rdata_i[20:16], imem_rdata_i[10:6]};

  a_r2_zero_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imem_rdata_i[25:21] == 5'd0) |-> (rs_data_i == 32'd0));

  a_r6_store_only_sw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != 6'd43) |-> !dmem_we_i);

  a_r8_seq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != 6'd2 && op != 6'd5) |=> (imem_addr_i == $past(nxt_w)));

  a_r9_bne_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 6'd5 && rs_data_i != rt_data_i) |=>
      (imem_addr_i == $past(nxt_w) + $past(off_w)));

  a_r9_bne_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 6'd5 && rs_data_i == rt_data_i) |=> (imem_addr_i == $past(nxt_w)));

  a_r10_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 6'd2) |=> (imem_addr_i == {$past(nxt_w[29:26]), $past(imem_rdata_i[25:0])}));

  a_r11_undef_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_ok |-> (!rf_we_i && !dmem_we_i));
endmodule

bind rc_core rc_core_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .imem_addr_i  (imem_addr_o),
  .imem_rdata_i (imem_rdata_i),
  .dmem_we_i    (dmem_we_o),
  .rs_data_i    (rs_data),
  .rt_data_i    (rt_data),
  .rf_we_i      (rf_we)
);

// File: tb/sim_rc_core.sv
module sim_rc_core;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [29:0] imem_addr;
  logic [31:0] imem_rdata, dmem_addr, dmem_wlanes, dmem_rlanes;
  logic        dmem_we;
  logic [31:0] imem [64];
  logic [7:0]  dmem [256];
  logic [7:0]  da;
  int          n_run = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rc_core u0 (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .imem_addr_o   (imem_addr),
    .imem_rdata_i  (imem_rdata),
    .dmem_addr_o   (dmem_addr),
    .dmem_we_o     (dmem_we),
    .dmem_wlanes_o (dmem_wlanes),
    .dmem_rlanes_i (dmem_rlanes)
  );

  assign imem_rdata  = imem[imem_addr[5:0]];
  assign da          = dmem_addr[7:0];
  assign dmem_rlanes = {dmem[da+8'd3], dmem[da+8'd2], dmem[da+8'd1], dmem[da]};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (dmem_we) begin
      dmem[da]      <= dmem_wlanes[7:0];
      dmem[da+8'd1] <= dmem_wlanes[15:8];
      dmem[da+8'd2] <= dmem_wlanes[23:16];
      dmem[da+8'd3] <= dmem_wlanes[31:24];
    end
  end

  function automatic logic [31:0] r_op(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] i_op(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] j_op(int idx);
    return {6'd2, 26'(idx)};
  endfunction
  function automatic logic [31:0] mem_word(int a);
    return {dmem[a], dmem[a+1], dmem[a+2], dmem[a+3]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // hold reset, wipe both memories with no-ops / zeros
  task automatic begin_prog();
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < 64; i++)  imem[i] = 32'd0;
    for (int i = 0; i < 256; i++) dmem[i] = 8'd0;
  endtask

  task automatic go(int cycles);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic t_alu();
    begin_prog();
    imem[0]  = i_op(8, 0, 1, 'h3C00);
    imem[1]  = i_op(8, 0, 2, 'h0DC0);
    imem[2]  = r_op(1, 2, 3, 0, 36);
    imem[3]  = r_op(1, 2, 4, 0, 37);
    imem[4]  = r_op(1, 0, 5, 0, 39);
    imem[5]  = r_op(1, 2, 6, 0, 32);
    imem[6]  = r_op(2, 1, 7, 0, 34);
    imem[7]  = i_op(8, 0, 8, -1);
    imem[8]  = r_op(5, 1, 9, 4, 0);     // rs=5 must not matter
    imem[9]  = r_op(7, 8, 10, 28, 2);
    for (int k = 3; k <= 10; k++) imem[k+7] = i_op(43, 0, k, 4*k);
    imem[18] = i_op(43, 0, 12, 48);
    imem[19] = j_op(19);
    go(40);
    chk("R3 and",        mem_word(12), 32'h0000_0C00);
    chk("R3 or",         mem_word(16), 32'h0000_3DC0);
    chk("R3 nor as not", mem_word(20), 32'hFFFF_C3FF);
    chk("R3 add",        mem_word(24), 32'h0000_49C0);
    chk("R3 sub",        mem_word(28), 32'hFFFF_D1C0);
    chk("R5 addi sext",  mem_word(32), 32'hFFFF_FFFF);
    chk("R4 sll",        mem_word(36), 32'h0003_C000);
    chk("R4 srl",        mem_word(40), 32'h0000_000F);
    chk("R1 unwritten reg", mem_word(48), 32'h0);
  endtask

  task automatic t_reset();
    begin_prog();
    imem[0] = i_op(43, 0, 5, 0);   // sw $5,0 : $5 held 0xFFFFC3FF before reset
    imem[1] = j_op(1);
    for (int i = 0; i < 4; i++) dmem[i] = 8'hAA;
    repeat (3) begin
      @(negedge clk);
      chk("R1 addr in reset", 32'(imem_addr), 32'd0);
      chk("R1 no store in reset", 32'(dmem_we), 32'd0);
    end
    chk("R1 mem untouched in reset", mem_word(0), 32'hAAAA_AAAA);
    go(5);
    chk("R1 regs cleared", mem_word(0), 32'h0);
  endtask

  task automatic t_zero();
    begin_prog();
    dmem[7] = 8'h5A;
    imem[0] = i_op(8, 0, 0, 'h123);
    imem[1] = i_op(8, 0, 1, 7);
    imem[2] = r_op(1, 1, 0, 0, 32);
    imem[3] = r_op(0, 1, 2, 0, 32);
    imem[4] = i_op(43, 0, 0, 0);
    imem[5] = i_op(43, 0, 2, 4);
    imem[6] = i_op(35, 0, 0, 4);    // lw into $0
    imem[7] = i_op(43, 0, 0, 8);
    imem[8] = r_op(1, 1, 1, 0, 32); // read and write $1 same cycle
    imem[9] = i_op(43, 0, 1, 12);
    imem[10] = j_op(10);
    go(20);
    chk("R2 addi to r0",   mem_word(0),  32'h0);
    chk("R2 r0 as source", mem_word(4),  32'h7);
    chk("R2 lw to r0",     mem_word(8),  32'h0);
    chk("R3 rmw same reg", mem_word(12), 32'd14);
  endtask

  task automatic t_mem();
    begin_prog();
    dmem[8'h40] = 8'h11; dmem[8'h41] = 8'h22;
    dmem[8'h42] = 8'h33; dmem[8'h43] = 8'h44;
    imem[0] = i_op(8, 0, 1, 'h50);
    imem[1] = i_op(35, 1, 2, -16);
    imem[2] = i_op(43, 1, 2, 4);
    imem[3] = r_op(0, 2, 3, 24, 2);
    imem[4] = i_op(43, 0, 3, 'h60);
    imem[5] = i_op(35, 0, 4, 'h42);
    imem[6] = i_op(43, 0, 4, 'h64);
    imem[7] = i_op(43, 0, 2, 'h6A);
    imem[8] = j_op(8);
    go(20);
    chk("R6 lw/sw neg offset", mem_word('h54), 32'h1122_3344);
    chk("R7 low addr = msb",   32'(dmem[8'h54]), 32'h11);
    chk("R7 high addr = lsb",  32'(dmem[8'h57]), 32'h44);
    chk("R7 loaded msb",       mem_word('h60), 32'h0000_0011);
    chk("R6 lw aligned",       mem_word('h64), 32'h1122_3344);
    chk("R6 sw aligned",       mem_word('h68), 32'h1122_3344);
    chk("R6 no spill",         mem_word('h6C), 32'h0);
  endtask

  task automatic t_branch();
    begin_prog();
    imem[0]  = i_op(8, 0, 1, 1);
    imem[1]  = i_op(8, 0, 2, 2);
    imem[2]  = i_op(5, 1, 2, 2);
    imem[3]  = i_op(8, 0, 3, 'h77);
    imem[4]  = i_op(8, 0, 3, 'h66);
    imem[5]  = i_op(8, 0, 4, 'h55);
    imem[6]  = i_op(5, 1, 1, 1);
    imem[7]  = i_op(8, 0, 5, 'h44);
    imem[8]  = i_op(8, 0, 6, 3);
    imem[9]  = i_op(8, 6, 6, -1);
    imem[10] = i_op(8, 7, 7, 2);
    imem[11] = i_op(5, 6, 0, -3);
    imem[12] = i_op(43, 0, 3, 0);
    imem[13] = i_op(43, 0, 4, 4);
    imem[14] = i_op(43, 0, 5, 8);
    imem[15] = i_op(43, 0, 7, 12);
    imem[16] = j_op(16);
    go(50);
    chk("R9 taken skips",     mem_word(0),  32'h0);
    chk("R9 taken target",    mem_word(4),  32'h55);
    chk("R9 equal falls",     mem_word(8),  32'h44);
    chk("R9 backward loop",   mem_word(12), 32'd6);
  endtask

  task automatic t_jump();
    begin_prog();
    imem[0]  = i_op(8, 0, 1, 'h21);
    imem[1]  = j_op(10);
    imem[2]  = i_op(8, 0, 1, 'h99);
    imem[10] = i_op(43, 0, 1, 0);
    imem[11] = j_op(11);
    @(negedge clk);
    rst_ni = 1'b1;
    chk("R1 first fetch", 32'(imem_addr), 32'd0);
    @(negedge clk); chk("R8 next word",   32'(imem_addr), 32'd1);
    @(negedge clk); chk("R10 jump index", 32'(imem_addr), 32'd10);
    @(negedge clk); chk("R8 after jump",  32'(imem_addr), 32'd11);
    @(negedge clk); chk("R10 self jump",  32'(imem_addr), 32'd11);
    chk("R10 skipped slot", mem_word(0), 32'h21);
  endtask

  task automatic t_undef();
    begin_prog();
    imem[0] = i_op(8, 0, 1, 9);
    imem[1] = r_op(0, 0, 1, 0, 63);
    imem[2] = i_op(63, 0, 1, 'h1234);
    imem[3] = i_op(4, 0, 0, 2);
    imem[4] = i_op(41, 0, 1, 8);
    imem[5] = i_op(43, 0, 1, 0);
    imem[6] = j_op(6);
    go(15);
    chk("R11 no reg write", mem_word(0), 32'd9);
    chk("R11 no store",     mem_word(8), 32'h0);
  endtask

  initial begin
    t_alu();
    t_reset();
    t_zero();
    t_mem();
    t_branch();
    t_jump();
    t_undef();
    summary();
    $finish;
  end

  initial begin
    wait (cyc >= WDOG_CYC);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got %0d cycles expected < %0d", cyc, WDOG_CYC);
    summary();
    $finish;
  end
endmodule